// File: doc/BRIEF.md
# Bus Address Decoder with Access Trap

This block sits between a processor's bus and its memories. For every access it sorts the address into one of three targets: boot ROM, main RAM, or the controller's own 256-byte register window. Each target has a select line. An address that none of the three covers raises a one-cycle trap pulse instead of a select. The reachable ROM and RAM extents come from a configuration register that software writes. After reset the extents are small, and boot code widens them once it knows how much memory is fitted.

Inside the register window the block holds a control register and the memory configuration register. The control register has three enables: power-down, soft reset and access protection. Each enable is driven out as a level for the logic that acts on it. Every other word offset in the window is plain read-back storage and never traps, so software written for a fuller register set still runs. Register writes take effect on the clock edge of the strobe. Register reads return data one cycle after the strobe.

Top module: `addr_trap_decoder`

## Requirements
- R1: The ROM starts at address 0x00000000. Its extent is 4 KB shifted left by the ROM size field, which is bits [2:0] of the configuration word at window offset 0x10. An access below that extent asserts sel_rom in the same cycle. The largest value, 7, gives 512 KB.
- R2: The RAM starts at address 0x02000000. Its extent is 256 KB shifted left by the RAM size field, which is bits [6:4] of the configuration word. Field values of 4 and above all give 4 MB. An access inside that extent asserts sel_ram in the same cycle.
- R3: Any access in 0x01F80000 to 0x01F800FF asserts sel_reg in the same cycle and never traps.
- R4: A valid access that no region covers asserts trap for that cycle only, with no select asserted. A valid access asserts exactly one of sel_rom, sel_ram, sel_reg and trap.
- R5: While acc_valid is low, no select and no trap is asserted, whatever the address.
- R6: After reset, the control word and the configuration word read 0. The reset decode is 4 KB of ROM and 256 KB of RAM, and the three enable outputs are low.
- R7: The control word is at window offset 0x00. Bit 0 drives pd_en, bit 1 drives swrst_en and bit 3 drives prot_en. All other bits read back as 0. The enable outputs change only on a write to that offset.
- R8: The configuration word keeps only its two size fields. All other bits are discarded and read back as 0.
- R9: A word written to any other offset in the window reads back unchanged. It alters neither the control word, nor the configuration word, nor the decoded extents.
- R10: Read data for a register read appears on rdata one cycle after the strobe. It holds until the next register read.
- R11: Writes that select ROM or RAM, or that trap, leave every register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access strobe, one cycle per access |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 32 | Byte address of the access |
| acc_wdata | input | 32 | Write data for register writes |
| sel_rom | output | 1 | Access targets ROM |
| sel_ram | output | 1 | Access targets RAM |
| sel_reg | output | 1 | Access targets the register window |
| trap | output | 1 | Memory exception pulse |
| rdata | output | 32 | Register read data, registered |
| pd_en | output | 1 | Power-down enable from the control word |
| swrst_en | output | 1 | Soft-reset enable from the control word |
| prot_en | output | 1 | Access-protection enable from the control word |

## Verification
Some properties hold on every cycle, and assertions check them all the time. Each valid access resolves to exactly one outcome, and an idle bus asserts none. The register window always wins. A ROM or RAM select never lands outside the largest legal extent. Read data and the enable levels change only after the matching register access. The bench's sweeps are what show the exact size boundaries. They step through all 64 pairs of size-field values and probe the last byte inside each extent and the first byte beyond it. The bench also shows that scratch words read back and leave the configuration alone, and that stray writes to memory or to trapping addresses change no register.

// File: rtl/addr_dec_pkg.sv
package addr_dec_pkg;

    typedef enum logic [1:0] {
        RGN_NONE = 2'd0,
        RGN_ROM  = 2'd1,
        RGN_RAM  = 2'd2,
        RGN_REG  = 2'd3
    } region_e;

    localparam int SZ_W        = 3;
    localparam int CTL_WORD    = 0;
    localparam int CFG_WORD    = 4;
    localparam int CFG_ROM_LSB = 0;
    localparam int CFG_RAM_LSB = 4;
    localparam int CTL_PD_BIT  = 0;
    localparam int CTL_SR_BIT  = 1;
    localparam int CTL_PR_BIT  = 3;
    localparam logic [3:0] CTL_MASK = 4'b1011;

endpackage

// File: rtl/region_decode.sv
module region_decode
    import addr_dec_pkg::*;
#(
    parameter int              ADDR_W       = 32,
    parameter logic [31:0]     ROM_BASE     = 32'h0000_0000,
    parameter logic [31:0]     RAM_BASE     = 32'h0200_0000,
    parameter logic [31:0]     REG_BASE     = 32'h01F8_0000,
    parameter int              REG_WIN_LOG2 = 8,
    parameter int              ROM_MIN_LOG2 = 12,
    parameter int              ROM_MAX_LOG2 = 19,
    parameter int              RAM_MIN_LOG2 = 18,
    parameter int              RAM_MAX_LOG2 = 22
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [SZ_W-1:0]   rom_sz,
    input  logic [SZ_W-1:0]   ram_sz,
    output region_e           region
);

    localparam logic [ADDR_W:0] ROM_BASE_X = {1'b0, ROM_BASE[ADDR_W-1:0]};
    localparam logic [ADDR_W:0] RAM_BASE_X = {1'b0, RAM_BASE[ADDR_W-1:0]};

    int unsigned       rom_lg;
    int unsigned       ram_lg;
    logic [ADDR_W:0]   rom_off;
    logic [ADDR_W:0]   ram_off;
    logic              rom_hit;
    logic              ram_hit;
    logic              reg_hit;

    always_comb begin
        rom_lg = ROM_MIN_LOG2 + int'(rom_sz);
        if (rom_lg > ROM_MAX_LOG2) rom_lg = ROM_MAX_LOG2;
        ram_lg = RAM_MIN_LOG2 + int'(ram_sz);
        if (ram_lg > RAM_MAX_LOG2) ram_lg = RAM_MAX_LOG2;

        // the extra top bit is the borrow: set when addr lies below the base
        rom_off = {1'b0, addr} - ROM_BASE_X;
        ram_off = {1'b0, addr} - RAM_BASE_X;
        rom_hit = !rom_off[ADDR_W] && ((rom_off[ADDR_W-1:0] >> rom_lg) == '0);
        ram_hit = !ram_off[ADDR_W] && ((ram_off[ADDR_W-1:0] >> ram_lg) == '0);
        reg_hit = (addr[ADDR_W-1:REG_WIN_LOG2] == REG_BASE[ADDR_W-1:REG_WIN_LOG2]);

        if (reg_hit)      region = RGN_REG;
        else if (rom_hit) region = RGN_ROM;
        else if (ram_hit) region = RGN_RAM;
        else              region = RGN_NONE;
    end

endmodule

// File: rtl/reg_window.sv
module reg_window
    import addr_dec_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 6,
    localparam int WORDS = 1 << IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [SZ_W-1:0]   rom_sz,
    output logic [SZ_W-1:0]   ram_sz,
    output logic              pd_en,
    output logic              swrst_en,
    output logic              prot_en,
    output logic [DATA_W-1:0] rdata
);

    typedef struct packed {
        logic [3:0]                   ctl;
        logic [SZ_W-1:0]              rom_sz;
        logic [SZ_W-1:0]              ram_sz;
        logic [WORDS-1:0][DATA_W-1:0] scratch;
        logic [DATA_W-1:0]            rdata;
    } win_state_t;

    win_state_t st_d;
    win_state_t st_q;
    logic [DATA_W-1:0] rd_word;

    always_comb begin
        rd_word = '0;
        if (int'(idx) == CTL_WORD) begin
            rd_word[3:0] = st_q.ctl & CTL_MASK;
        end else if (int'(idx) == CFG_WORD) begin
            rd_word[CFG_ROM_LSB +: SZ_W] = st_q.rom_sz;
            rd_word[CFG_RAM_LSB +: SZ_W] = st_q.ram_sz;
        end else begin
            rd_word = st_q.scratch[idx];
        end

        st_d = st_q;
        if (rd_en) st_d.rdata = rd_word;
        if (wr_en) begin
            if (int'(idx) == CTL_WORD) begin
                st_d.ctl = wdata[3:0] & CTL_MASK;
            end else if (int'(idx) == CFG_WORD) begin
                st_d.rom_sz = wdata[CFG_ROM_LSB +: SZ_W];
                st_d.ram_sz = wdata[CFG_RAM_LSB +: SZ_W];
            end else begin
                st_d.scratch[idx] = wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rom_sz   = st_q.rom_sz;
    assign ram_sz   = st_q.ram_sz;
    assign pd_en    = st_q.ctl[CTL_PD_BIT];
    assign swrst_en = st_q.ctl[CTL_SR_BIT];
    assign prot_en  = st_q.ctl[CTL_PR_BIT];
    assign rdata    = st_q.rdata;

endmodule

// File: rtl/addr_trap_decoder.sv
module addr_trap_decoder
    import addr_dec_pkg::*;
#(
    parameter int          ADDR_W       = 32,
    parameter int          DATA_W       = 32,
    parameter logic [31:0] ROM_BASE     = 32'h0000_0000,
    parameter logic [31:0] RAM_BASE     = 32'h0200_0000,
    parameter logic [31:0] REG_BASE     = 32'h01F8_0000,
    parameter int          REG_WIN_LOG2 = 8,
    parameter int          ROM_MIN_LOG2 = 12,
    parameter int          ROM_MAX_LOG2 = 19,
    parameter int          RAM_MIN_LOG2 = 18,
    parameter int          RAM_MAX_LOG2 = 22
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [DATA_W-1:0] acc_wdata,
    output logic              sel_rom,
    output logic              sel_ram,
    output logic              sel_reg,
    output logic              trap,
    output logic [DATA_W-1:0] rdata,
    output logic              pd_en,
    output logic              swrst_en,
    output logic              prot_en
);

    localparam int IDX_W = REG_WIN_LOG2 - 2;

    region_e          region;
    logic [SZ_W-1:0]  rom_sz;
    logic [SZ_W-1:0]  ram_sz;
    logic             rd_en;
    logic             wr_en;

    region_decode #(
        .ADDR_W       (ADDR_W),
        .ROM_BASE     (ROM_BASE),
        .RAM_BASE     (RAM_BASE),
        .REG_BASE     (REG_BASE),
        .REG_WIN_LOG2 (REG_WIN_LOG2),
        .ROM_MIN_LOG2 (ROM_MIN_LOG2),
        .ROM_MAX_LOG2 (ROM_MAX_LOG2),
        .RAM_MIN_LOG2 (RAM_MIN_LOG2),
        .RAM_MAX_LOG2 (RAM_MAX_LOG2)
    ) u_dec (
        .addr   (acc_addr),
        .rom_sz (rom_sz),
        .ram_sz (ram_sz),
        .region (region)
    );

    always_comb begin
        sel_rom = acc_valid && (region == RGN_ROM);
        sel_ram = acc_valid && (region == RGN_RAM);
        sel_reg = acc_valid && (region == RGN_REG);
        trap    = acc_valid && (region == RGN_NONE);
        rd_en   = sel_reg && !acc_write;
        wr_en   = sel_reg && acc_write;
    end

    reg_window #(
        .DATA_W (DATA_W),
        .IDX_W  (IDX_W)
    ) u_win (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_en    (rd_en),
        .wr_en    (wr_en),
        .idx      (acc_addr[REG_WIN_LOG2-1:2]),
        .wdata    (acc_wdata),
        .rom_sz   (rom_sz),
        .ram_sz   (ram_sz),
        .pd_en    (pd_en),
        .swrst_en (swrst_en),
        .prot_en  (prot_en),
        .rdata    (rdata)
    );

endmodule

// File: rtl/addr_trap_decoder_chk.sv
module addr_trap_decoder_chk #(
    parameter int          ADDR_W       = 32,
    parameter int          DATA_W       = 32,
    parameter logic [31:0] RAM_BASE     = 32'h0200_0000,
    parameter logic [31:0] REG_BASE     = 32'h01F8_0000,
    parameter int          REG_WIN_LOG2 = 8,
    parameter int          ROM_MAX_LOG2 = 19,
    parameter int          RAM_MAX_LOG2 = 22
) (
    input logic              clk,
    input logic              rst_n,
    input logic              acc_valid,
    input logic              acc_write,
    input logic [ADDR_W-1:0] acc_addr,
    input logic              sel_rom,
    input logic              sel_ram,
    input logic              sel_reg,
    input logic              trap,
    input logic [DATA_W-1:0] rdata,
    input logic              pd_en,
    input logic              swrst_en,
    input logic              prot_en
);

    localparam logic [ADDR_W:0] ROM_LIMIT = (ADDR_W+1)'(1) << ROM_MAX_LOG2;
    localparam logic [ADDR_W:0] RAM_LO    = {1'b0, RAM_BASE[ADDR_W-1:0]};
    localparam logic [ADDR_W:0] RAM_HI    = RAM_LO + ((ADDR_W+1)'(1) << RAM_MAX_LOG2);

    // R4
    one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |-> $countones({sel_rom, sel_ram, sel_reg, trap}) == 1);

    // R5
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |-> !(sel_rom || sel_ram || sel_reg || trap));

    // R3
    window_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_addr[ADDR_W-1:REG_WIN_LOG2] == REG_BASE[ADDR_W-1:REG_WIN_LOG2])
        |-> sel_reg);

    // R1
    rom_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_rom |-> ({1'b0, acc_addr} < ROM_LIMIT));

    // R2
    ram_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_ram |-> ({1'b0, acc_addr} >= RAM_LO && {1'b0, acc_addr} < RAM_HI));

    // R10
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(sel_reg && !acc_write) |=> $stable(rdata));

    // R7
    ctl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(sel_reg && acc_write && acc_addr[REG_WIN_LOG2-1:2] == '0)
        |=> $stable({pd_en, swrst_en, prot_en}));

endmodule

bind addr_trap_decoder addr_trap_decoder_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_valid (acc_valid),
    .acc_write (acc_write),
    .acc_addr  (acc_addr),
    .sel_rom   (sel_rom),
    .sel_ram   (sel_ram),
    .sel_reg   (sel_reg),
    .trap      (trap),
    .rdata     (rdata),
    .pd_en     (pd_en),
    .swrst_en  (swrst_en),
    .prot_en   (prot_en)
);

// File: tb/sim_addr_trap_decoder.sv
module sim_addr_trap_decoder;

    localparam logic [31:0] RAMB = 32'h0200_0000;
    localparam logic [31:0] REGB = 32'h01F8_0000;
    localparam logic [31:0] CFGA = REGB + 32'h10;
    // one-hot outcome codes {sel_reg, sel_ram, sel_rom, trap}
    localparam logic [3:0] O_TRAP = 4'b0001;
    localparam logic [3:0] O_ROM  = 4'b0010;
    localparam logic [3:0] O_RAM  = 4'b0100;
    localparam logic [3:0] O_REG  = 4'b1000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic        acc_write = 1'b0;
    logic [31:0] acc_addr = '0;
    logic [31:0] acc_wdata = '0;
    logic        sel_rom, sel_ram, sel_reg, trap;
    logic [31:0] rdata;
    logic        pd_en, swrst_en, prot_en;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    addr_trap_decoder u0 (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_addr(acc_addr), .acc_wdata(acc_wdata), .sel_rom(sel_rom),
        .sel_ram(sel_ram), .sel_reg(sel_reg), .trap(trap), .rdata(rdata),
        .pd_en(pd_en), .swrst_en(swrst_en), .prot_en(prot_en)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = 1'b1; acc_addr = a; acc_wdata = d;
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b0;
    endtask

    task automatic rd(input logic [31:0] a, output logic [31:0] d);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = 1'b0; acc_addr = a;
        @(negedge clk);
        d = rdata;
        acc_valid = 1'b0;
    endtask

    task automatic probe(input string req, input logic [31:0] a, input logic [3:0] exp);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = 1'b0; acc_addr = a;
        #1;
        chk(req, {28'd0, sel_reg, sel_ram, sel_rom, trap}, {28'd0, exp});
        acc_valid = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [31:0] rom_bytes, ram_bytes;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R6 reset state
        #1;
        chk("R6 rdata", rdata, 32'h0);
        chk("R6 enables", {29'd0, pd_en, swrst_en, prot_en}, 32'h0);
        chk("R5 idle", {28'd0, sel_reg, sel_ram, sel_rom, trap}, 32'h0);
        rd(REGB, v);        chk("R6 ctl", v, 32'h0);
        rd(CFGA, v);        chk("R6 cfg", v, 32'h0);
        probe("R6 rom last", 32'h0000_0FFF, O_ROM);
        probe("R6 rom out", 32'h0000_1000, O_TRAP);
        probe("R6 ram last", RAMB + 32'h3_FFFF, O_RAM);
        probe("R6 ram out", RAMB + 32'h4_0000, O_TRAP);

        // R1 R2 sweep over every pair of size fields
        for (int p = 0; p < 8; p++) begin
            for (int r = 0; r < 8; r++) begin
                wr(CFGA, (r << 4) | p);
                rd(CFGA, v);
                chk("R8 cfg readback", v, (r << 4) | p);
                rom_bytes = 32'h1000 << p;
                ram_bytes = 32'h4_0000 << ((r > 4) ? 4 : r);
                probe("R1 rom first", 32'h0, O_ROM);
                probe("R1 rom last", rom_bytes - 1, O_ROM);
                probe("R1 rom beyond", rom_bytes, O_TRAP);
                probe("R2 ram first", RAMB, O_RAM);
                probe("R2 ram last", RAMB + ram_bytes - 1, O_RAM);
                probe("R2 ram beyond", RAMB + ram_bytes, O_TRAP);
                probe("R4 below ram", RAMB - 4, O_TRAP);
            end
        end

        // R8 unused bits discarded
        wr(CFGA, 32'hFFFF_FFFF);
        rd(CFGA, v);        chk("R8 masked", v, 32'h77);

        // R3 window edges
        probe("R3 window low", REGB, O_REG);
        probe("R3 window high", REGB + 32'hFF, O_REG);
        probe("R3 below window", REGB - 1, O_TRAP);
        probe("R3 above window", REGB + 32'h100, O_TRAP);

        // R4 single-cycle trap
        probe("R4 trap", 32'hFFFF_0000, O_TRAP);
        @(negedge clk); #1;
        chk("R4 trap drops", {31'd0, trap}, 32'h0);

        // R5 strobe low with addresses of each region
        @(negedge clk);
        acc_valid = 1'b0; acc_addr = REGB; #1;
        chk("R5 reg addr idle", {28'd0, sel_reg, sel_ram, sel_rom, trap}, 32'h0);
        acc_addr = 32'hFFFF_0000; #1;
        chk("R5 trap addr idle", {28'd0, sel_reg, sel_ram, sel_rom, trap}, 32'h0);

        // R7 control word
        wr(REGB, 32'hFFFF_FFFF);
        #1;
        chk("R7 enables set", {29'd0, pd_en, swrst_en, prot_en}, 32'h7);
        rd(REGB, v);        chk("R7 ctl readback", v, 32'hB);
        wr(REGB, 32'h0000_0004);
        #1;
        chk("R7 enables clr", {29'd0, pd_en, swrst_en, prot_en}, 32'h0);
        rd(REGB, v);        chk("R7 bit2 dropped", v, 32'h0);
        wr(REGB, 32'h0000_0002);
        #1;
        chk("R7 swrst only", {29'd0, pd_en, swrst_en, prot_en}, 32'h2);

        // R9 scratch words
        wr(CFGA, 32'h0000_0021);
        for (int i = 0; i < 64; i++) begin
            if (i != 0 && i != 4) wr(REGB + 32'(i * 4), 32'hA500_0000 ^ (32'(i) * 32'h0101_0101));
        end
        for (int i = 0; i < 64; i++) begin
            if (i != 0 && i != 4) begin
                rd(REGB + 32'(i * 4), v);
                chk("R9 scratch", v, 32'hA500_0000 ^ (32'(i) * 32'h0101_0101));
            end
        end
        rd(REGB, v);        chk("R9 ctl kept", v, 32'h2);
        rd(CFGA, v);        chk("R9 cfg kept", v, 32'h21);
        probe("R9 rom extent kept", 32'h0000_1FFF, O_ROM);
        probe("R9 rom extent kept", 32'h0000_2000, O_TRAP);
        probe("R9 ram extent kept", RAMB + 32'h10_0000, O_TRAP);

        // R11 stray writes
        wr(32'h0000_0010, 32'hFFFF_FFFF);
        wr(RAMB + 32'h10, 32'hFFFF_FFFF);
        wr(32'hFFFF_0010, 32'hFFFF_FFFF);
        #1;
        chk("R11 enables kept", {29'd0, pd_en, swrst_en, prot_en}, 32'h2);
        rd(CFGA, v);        chk("R11 cfg kept", v, 32'h21);
        rd(REGB + 32'h4, v); chk("R11 scratch kept", v, 32'hA500_0000 ^ 32'h0101_0101);

        // R10 read latency and hold
        @(negedge clk);
        acc_valid = 1'b1; acc_write = 1'b0; acc_addr = CFGA;
        #1;
        chk("R10 not yet", rdata, 32'hA500_0000 ^ 32'h0101_0101);
        @(negedge clk);
        chk("R10 one cycle", rdata, 32'h21);
        acc_valid = 1'b0;
        probe("R10 rom read", 32'h0, O_ROM);
        repeat (3) @(negedge clk);
        chk("R10 holds", rdata, 32'h21);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule